// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR SRAM

This block models a synchronous static memory with one read data bus and one write data bus. Both move one word on the rising clock edge and one on the falling edge. Every request transfers a fixed group of four words, so the caller names only a four-word block. The two low word-address bits are generated inside and step 0, 1, 2, 3 across the burst. A read and a write may start in the same cycle. The write is masked lane by lane with active-high enables.

One block-address bus is shared by both ports. A read takes its block on the rising edge that accepts it. A write takes its block on the falling edge that follows the rising edge accepting it. The read path is a three-stage pipeline. It stays coherent with writes: a write whose words are still arriving is forwarded into the read beats it overlaps. The array is split into an even-word bank clocked on the falling edge and an odd-word bank clocked on the rising edge. The read output shows whichever bank launched last, selected by the clock level.

Top module: `qb4_sram`

## Requirements
- R1: A burst covers word addresses block*4+0 to block*4+3, in beat order 0, 1, 2, 3. Beats 0 and 2 move on falling edges and beats 1 and 3 on rising edges.
- R2: A write is accepted on a rising edge while `wr_req` is high. Its block address and beat 0 are taken on the falling edge that follows. Beat 1 is taken on the next rising edge, beat 2 on the falling edge after that, and beat 3 on the rising edge after that.
- R3: `wr_be` bit i enables bits [i*LANE_W +: LANE_W] of the beat taken on the same edge. Disabled lanes keep their stored value, and an all-zero `wr_be` leaves the word unchanged.
- R4: A read accepted on rising edge n launches beat 0 on the falling edge 1.5 cycles later. Beats 1, 2 and 3 follow on the next three edges. `rd_valid` is high for exactly those four half-cycles. While `clk` is high, `rd_data` shows the word launched on the last rising edge; while `clk` is low, it shows the word launched on the last falling edge.
- R5: Each port accepts at most one request every two cycles. A request in the cycle right after an accept on the same port is ignored: it returns no data and changes no word.
- R6: A read and a write may be accepted on the same rising edge, to the same block or to different blocks, and both complete.
- R7: Word k of a read accepted in cycle n returns the data of any write accepted in cycle n+1 or earlier, with the lanes that write enabled. A write accepted in cycle n+2 or later is not visible to that read.
- R8: Read requests made every second cycle give a gap-free `rd_valid`. Write requests made every second cycle all complete.
- R9: Reset clears the pipelines: `rd_valid` is low during reset and a burst in progress is dropped. Array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges move data |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| rd_req | input | 1 | Read request, sampled on rising edges |
| wr_req | input | 1 | Write request, sampled on rising edges |
| blk_addr | input | BLK_AW | Block address: read on rising edge, write on falling edge |
| wr_data | input | DATA_W | Write beat data, one word per edge |
| wr_be | input | DATA_W/LANE_W | Active-high lane write enables for the current beat |
| rd_data | output | DATA_W | Read beat data |
| rd_valid | output | 1 | High while `rd_data` carries a read beat |

## Verification
The functions that can coincide are a read burst being launched and a write burst being committed. This happens on the same edges and can target the same words. The stimulus table provokes this in four ways: a read and a write to one block on the same edge; a write arriving one cycle after a read to the same block; a write two cycles after a read, which must stay invisible; and partial-lane writes overlapping a read. Each half-cycle's `rd_data` is judged against a reference array that the bench updates at the exact edge each write beat lands, with writes applied before reads on a shared edge.

// File: rtl/qb4_pkg.sv
`timescale 1ns/1ps
package qb4_pkg;
   // write port phase: first or second cycle of a burst
   typedef enum logic [1:0] {
      WPH_IDLE = 2'd0,
      WPH_LO   = 2'd1,
      WPH_HI   = 2'd2
   } wph_e;
endpackage

// File: rtl/qb4_wr_seq.sv
`timescale 1ns/1ps
module qb4_wr_seq
   import qb4_pkg::*;
#(
   parameter int BLK_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [BLK_AW-1:0] blk_addr,
   output logic              acc,
   output logic              ev_we,
   output logic [BLK_AW:0]   ev_idx,
   output logic              od_we,
   output logic [BLK_AW:0]   od_idx
);
   wph_e              ph;
   logic [BLK_AW-1:0] blk_q;

   assign acc = wr_req && (ph != WPH_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ph <= WPH_IDLE;
      else if (acc)            ph <= WPH_LO;
      else if (ph == WPH_LO)   ph <= WPH_HI;
      else                     ph <= WPH_IDLE;
   end

   // block address arrives with beat 0 on the falling edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)              blk_q <= '0;
      else if (ph == WPH_LO)   blk_q <= blk_addr;
   end

   // even bank (falling edge): beat 0 then beat 2
   assign ev_we  = (ph != WPH_IDLE);
   assign ev_idx = (ph == WPH_LO) ? {blk_addr, 1'b0} : {blk_q, 1'b1};
   // odd bank (rising edge): beat 1 then beat 3
   assign od_we  = (ph != WPH_IDLE);
   assign od_idx = {blk_q, (ph == WPH_HI)};
endmodule

// File: rtl/qb4_rd_seq.sv
`timescale 1ns/1ps
module qb4_rd_seq #(
   parameter int BLK_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [BLK_AW-1:0] blk_addr,
   output logic              acc,
   output logic              re,
   output logic [BLK_AW:0]   ridx
);
   logic              st1, st2, st3;
   logic [BLK_AW-1:0] bk1, bk2, bk3;

   assign acc = rd_req && !st1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st1 <= 1'b0; st2 <= 1'b0; st3 <= 1'b0;
         bk1 <= '0;   bk2 <= '0;   bk3 <= '0;
      end else begin
         st1 <= acc;
         st2 <= st1;
         st3 <= st2;
         if (acc) bk1 <= blk_addr;
         bk2 <= bk1;
         bk3 <= bk2;
      end
   end

   // both banks use the same index: low half in stage 2, high half in stage 3
   assign re   = st2 | st3;
   assign ridx = st2 ? {bk2, 1'b0} : {bk3, 1'b1};
endmodule

// File: rtl/qb4_bank.sv
`timescale 1ns/1ps
module qb4_bank #(
   parameter int DATA_W = 18,
   parameter int LANE_W = 9,
   parameter int IDX_W  = 5,
   parameter bit RISE   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [IDX_W-1:0]         widx,
   input  logic [DATA_W/LANE_W-1:0] wbe,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     re,
   input  logic [IDX_W-1:0]         ridx,
   output logic [DATA_W-1:0]        q,
   output logic                     qv
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int WORDS = 1 << IDX_W;

   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] rd_word;

   always_comb begin
      merged = mem[widx];
      for (int l = 0; l < LANES; l++)
         if (wbe[l]) merged[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
   end

   // write-first forwarding when a beat lands on the word being launched
   assign rd_word = (we && (widx == ridx)) ? merged : mem[ridx];

   generate
      if (RISE) begin : g_rise
         always_ff @(posedge clk) begin
            if (we) mem[widx] <= merged;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0; qv <= 1'b0;
            end else begin
               qv <= re;
               if (re) q <= rd_word;
            end
         end
      end else begin : g_fall
         always_ff @(negedge clk) begin
            if (we) mem[widx] <= merged;
         end
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0; qv <= 1'b0;
            end else begin
               qv <= re;
               if (re) q <= rd_word;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qb4_sram.sv
`timescale 1ns/1ps
module qb4_sram #(
   parameter int DATA_W = 18,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 64,
   localparam int LANES   = DATA_W / LANE_W,
   localparam int WORD_AW = $clog2(DEPTH),
   localparam int BLK_AW  = WORD_AW - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [BLK_AW-1:0] blk_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_be,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int IDX_W = BLK_AW + 1;

   generate
      if ((DATA_W % LANE_W) != 0) begin : g_bad_lane
         $error("qb4_sram: DATA_W must be a whole number of lanes");
      end
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("qb4_sram: DEPTH must be a power of two of at least 8");
      end
   endgenerate

   logic              rd_acc, wr_acc, rd_re;
   logic [IDX_W-1:0]  rd_idx;
   logic [1:0]        b_we;
   logic [IDX_W-1:0]  b_widx [2];
   logic [DATA_W-1:0] b_q    [2];
   logic [1:0]        b_v;

   qb4_wr_seq #(.BLK_AW(BLK_AW)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .blk_addr(blk_addr),
      .acc(wr_acc),
      .ev_we(b_we[0]), .ev_idx(b_widx[0]),
      .od_we(b_we[1]), .od_idx(b_widx[1])
   );

   qb4_rd_seq #(.BLK_AW(BLK_AW)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .blk_addr(blk_addr),
      .acc(rd_acc), .re(rd_re), .ridx(rd_idx)
   );

   // bank 0 holds even beats (falling edge), bank 1 odd beats (rising edge)
   for (genvar b = 0; b < 2; b++) begin : g_bank
      qb4_bank #(
         .DATA_W(DATA_W), .LANE_W(LANE_W), .IDX_W(IDX_W), .RISE(b == 1)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .we(b_we[b]), .widx(b_widx[b]), .wbe(wr_be), .wdata(wr_data),
         .re(rd_re), .ridx(rd_idx),
         .q(b_q[b]), .qv(b_v[b])
      );
   end

   assign rd_data  = clk ? b_q[1] : b_q[0];
   assign rd_valid = clk ? b_v[1] : b_v[0];
endmodule

// File: rtl/qb4_sram_chk.sv
`timescale 1ns/1ps
module qb4_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_acc,
   input logic wr_acc,
   input logic ev_v,
   input logic od_v
);
   // R4
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |-> ##2 ev_v ##1 (ev_v && od_v) ##1 od_v);

   // R4
   rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(od_v) |=> od_v);

   // R5
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> !rd_acc);

   // R5
   wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> !wr_acc);

   // R9
   always @(negedge clk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!ev_v && !od_v);
      end
   end
endmodule

bind qb4_sram qb4_sram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .wr_acc(wr_acc),
   .ev_v(b_v[0]), .od_v(b_v[1])
);

// File: tb/qb4_sram_tb.sv
`timescale 1ns/1ps
module qb4_sram_tb;
   localparam int N_OP = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        rd_req = 1'b0, wr_req = 1'b0;
   logic [3:0]  blk_addr = '0;
   logic [17:0] wr_data = '0;
   logic [1:0]  wr_be = '0;
   logic [17:0] rd_data;
   logic        rd_valid;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   qb4_sram u_dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
      .blk_addr(blk_addr), .wr_data(wr_data), .wr_be(wr_be),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   always #10 clk = ~clk;

   // op: [19] rd, [18:15] read block, [14] wr, [13:10] write block, [9:8] lane enables, [7:0] seed
   localparam logic [19:0] OPS [N_OP] = '{
      {1'b1,4'd3, 1'b1,4'd3, 2'b11,8'd1},   // R6 R7 same block, same cycle
      {1'b1,4'd6, 1'b1,4'd5, 2'b11,8'd9},   // R5 both ignored while busy
      {1'b1,4'd7, 1'b0,4'd0, 2'b00,8'd0},   // R8 back-to-back reads
      {1'b0,4'd0, 1'b1,4'd7, 2'b01,8'd2},   // R7 write one cycle after read, R3 lane 0
      {1'b1,4'd3, 1'b0,4'd0, 2'b00,8'd0},
      {1'b0,4'd0, 1'b1,4'd8, 2'b10,8'd3},   // R3 lane 1 only
      {1'b1,4'd5, 1'b0,4'd0, 2'b00,8'd0},   // R5 block 5 untouched
      {1'b0,4'd0, 1'b1,4'd9, 2'b00,8'd4},   // R3 no lanes
      {1'b1,4'd9, 1'b0,4'd0, 2'b00,8'd0},
      {1'b0,4'd0, 1'b1,4'd10,2'b11,8'd5},
      {1'b1,4'd8, 1'b0,4'd0, 2'b00,8'd0},
      {1'b0,4'd0, 1'b1,4'd8, 2'b01,8'd6},   // R7 partial write after read
      {1'b1,4'd10,1'b0,4'd0, 2'b00,8'd0},
      {1'b0,4'd0, 1'b0,4'd0, 2'b00,8'd0},
      {1'b1,4'd15,1'b0,4'd0, 2'b00,8'd0},
      {1'b0,4'd0, 1'b0,4'd0, 2'b00,8'd0},
      {1'b1,4'd15,1'b1,4'd15,2'b11,8'd7},   // R7 invisible to earlier read
      {1'b0,4'd0, 1'b0,4'd0, 2'b00,8'd0},
      {1'b1,4'd14,1'b1,4'd14,2'b11,8'd8},   // R6 R8 back-to-back writes
      {1'b0,4'd0, 1'b0,4'd0, 2'b00,8'd0}
   };

   logic [17:0] ref_mem [64];
   int          w_ph;
   logic [3:0]  w_blk;
   logic [7:0]  w_seed;
   logic [1:0]  w_be;
   bit          r_s1, r_s2, r_s3;
   logic [3:0]  r_b1, r_b2, r_b3;

   function automatic logic [17:0] beat_val(logic [7:0] s, int k);
      logic [31:0] t;
      t = 32'(s) * 32'd40503 + 32'(k) * 32'd9973 + 32'h2b5;
      return t[17:0];
   endfunction

   task automatic ref_wr(int k);
      logic [17:0] d;
      logic [5:0]  w;
      d = beat_val(w_seed, k);
      w = {w_blk, 2'(k)};
      for (int l = 0; l < 2; l++)
         if (w_be[l]) ref_mem[w][l*9 +: 9] = d[l*9 +: 9];
   endtask

   task automatic compare(input bit ev, input logic [17:0] ed, input string lbl);
      n_cmp++;
      if (rd_valid !== ev) begin
         n_bad++;
         $display("FAIL %s rd_valid at %0t: got %b expected %b", lbl, $time, rd_valid, ev);
      end
      if (ev) begin
         n_cmp++;
         if (rd_data !== ed) begin
            n_bad++;
            $display("FAIL %s rd_data at %0t: got %h expected %h", lbl, $time, rd_data, ed);
         end
      end
   endtask

   // starts 5 ns before a rising edge, ends 5 ns before the next one
   task automatic run_cycle(input logic [19:0] op, input string lbl);
      bit racc, wacc, ev;
      logic [17:0] ed;
      racc = op[19] && !r_s1;
      wacc = op[14] && (w_ph != 1);
      rd_req   = op[19];
      wr_req   = op[14];
      blk_addr = op[18:15];
      if (w_ph == 1)      begin wr_data = beat_val(w_seed, 1); wr_be = w_be; end
      else if (w_ph == 2) begin wr_data = beat_val(w_seed, 3); wr_be = w_be; end
      else                begin wr_data = '0; wr_be = '0; end
      @(posedge clk);
      if (w_ph == 1) ref_wr(1);
      if (w_ph == 2) ref_wr(3);
      ev = r_s2 | r_s3;
      ed = r_s2 ? ref_mem[{r_b2, 2'd1}] : ref_mem[{r_b3, 2'd3}];
      w_ph = wacc ? 1 : ((w_ph == 1) ? 2 : 0);
      if (wacc) begin w_blk = op[13:10]; w_be = op[9:8]; w_seed = op[7:0]; end
      r_s3 = r_s2; r_s2 = r_s1; r_s1 = racc;
      r_b3 = r_b2; r_b2 = r_b1;
      if (racc) r_b1 = op[18:15];
      #5;
      compare(ev, ed, lbl);
      rd_req = 1'b0; wr_req = 1'b0;
      if (w_ph == 1)      begin blk_addr = w_blk; wr_data = beat_val(w_seed, 0); wr_be = w_be; end
      else if (w_ph == 2) begin wr_data = beat_val(w_seed, 2); wr_be = w_be; end
      else                begin wr_data = '0; wr_be = '0; end
      @(negedge clk);
      if (w_ph == 1) ref_wr(0);
      if (w_ph == 2) ref_wr(2);
      ev = r_s2 | r_s3;
      ed = r_s2 ? ref_mem[{r_b2, 2'd0}] : ref_mem[{r_b3, 2'd2}];
      #5;
      compare(ev, ed, lbl);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [19:0] op;
      for (int i = 0; i < 64; i++) ref_mem[i] = '0;
      w_ph = 0; w_blk = '0; w_seed = '0; w_be = '0;
      r_s1 = 0; r_s2 = 0; r_s3 = 0; r_b1 = '0; r_b2 = '0; r_b3 = '0;
      #1 rst_n = 1'b0;
      #34;                      // t=35, clock high, in reset
      n_cmp++;
      if (rd_valid !== 1'b0) begin
         n_bad++; $display("FAIL R9 reset: rd_valid got %b expected 0", rd_valid);
      end
      #10 rst_n = 1'b1;         // t=45, 5 ns before a rising edge
      n_cmp++;
      if (rd_valid !== 1'b0) begin
         n_bad++; $display("FAIL R9 after reset: rd_valid got %b expected 0", rd_valid);
      end
      // fill every block with full-lane writes every second cycle (R2 R8)
      for (int b = 0; b < 16; b++) begin
         op = {1'b0, 4'd0, 1'b1, 4'(b), 2'b11, 8'(100 + b)};
         run_cycle(op, "R2");
         run_cycle('0, "R2");
      end
      // stimulus table: R1 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < N_OP; i++) run_cycle(OPS[i], "R1 R3 R4 R5 R6 R7 R8");
      for (int i = 0; i < 3; i++) run_cycle('0, "R4");
      // R9: reset in the middle of a read burst
      rd_req = 1'b1; blk_addr = 4'd3; wr_req = 1'b0; wr_be = '0;
      @(posedge clk);
      #5;
      rd_req = 1'b0;
      rst_n  = 1'b0;
      for (int h = 0; h < 4; h++) begin
         #10;
         n_cmp++;
         if (rd_valid !== 1'b0) begin
            n_bad++; $display("FAIL R9 burst dropped: rd_valid got %b expected 0", rd_valid);
         end
      end
      #10 rst_n = 1'b1;
      w_ph = 0; r_s1 = 0; r_s2 = 0; r_s3 = 0;
      // R9: contents survive reset
      run_cycle({1'b1, 4'd3, 1'b0, 4'd0, 2'b00, 8'd0}, "R9");
      run_cycle({1'b1, 4'd14, 1'b0, 4'd0, 2'b00, 8'd0}, "R9");
      run_cycle({1'b1, 4'd8, 1'b0, 4'd0, 2'b00, 8'd0}, "R9");
      for (int i = 0; i < 3; i++) run_cycle('0, "R9");
      done = 1;
      finish_run();
   end
endmodule